// File: doc/BRIEF.md
# Reset Sequencer With Watchdog

This block produces the internal reset of a small microcontroller core. An active-low power-on input and an external clear input both force the core into reset. Once the clear input is high, a hold-off timer counts ticks of a slow on-chip RC tick, and the core leaves reset when the timer finishes. The hold-off length depends on the oscillator mode. It also depends on whether this is the first reset after power-on or a later reset. RC oscillator modes come up faster on later resets. Crystal-type modes always wait the long interval.

A watchdog counter runs from the same slow tick, independent of the processor clock, and keeps counting while the core sleeps. If software does not pulse `wdt_clear` before the period ends, the watchdog expires. Expiry re-enters the hold-off timer and clears the time-out flag. When the core was asleep, expiry also raises a wake-up indication. A configuration bit turns the watchdog off for good. All lengths are parameters in tick counts. `clk` is the fast RC clock that samples everything, and `tick` is a one-cycle enable marking each slow tick.

Top module: `rst_seq_wdt`

## Requirements
- R1: While `por_n` is low, `internal_reset` is 1, `to_flag` is 1 and `wake_event` is 0.
- R2: `internal_reset` is 1 in any cycle in which `mclr` is low. No tick counts toward the hold-off while `mclr` is low, and counting starts with the first tick after `mclr` is high.
- R3: The first hold-off after `por_n` is released lasts exactly LONG_TICKS ticks with `mclr` high, for every oscillator mode.
- R4: Later hold-offs last SHORT_TICKS ticks in the RC oscillator modes, `osc_mode` = 2'b10 (internal RC) and 2'b11 (external RC).
- R5: Later hold-offs last LONG_TICKS ticks in the crystal modes, `osc_mode` = 2'b00 (low power) and 2'b01 (standard crystal).
- R6: The watchdog is held at zero while `internal_reset` is 1. With `wdt_en` = 1 and no `wdt_clear`, it expires on the WDT_TICKS-th tick after reset release. `internal_reset` is 1 from that edge on, and a later-type hold-off follows.
- R7: `to_flag` goes to 0 at watchdog expiry.
- R8: With `wdt_en` = 0 the watchdog never expires, however many ticks pass.
- R9: A `wdt_clear` pulse zeroes the watchdog count and sets `to_flag` to 1 from the next edge. Clears spaced fewer than WDT_TICKS ticks apart prevent any reset.
- R10: Expiry while `sleep` = 1 sets `wake_event` at the expiry edge, and it clears on the next tick. Expiry with `sleep` = 0 leaves `wake_event` at 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | On-chip RC clock that samples all inputs |
| por_n | input | 1 | Power-on reset, active low, asynchronous |
| mclr | input | 1 | External clear, low forces reset |
| tick | input | 1 | One-cycle strobe per slow tick |
| sleep | input | 1 | Core is in sleep |
| wdt_clear | input | 1 | Watchdog clear pulse from the core |
| osc_mode | input | 2 | Oscillator mode: 00 low power, 01 crystal, 10 internal RC, 11 external RC |
| wdt_en | input | 1 | Watchdog enable configuration bit |
| internal_reset | output | 1 | Reset to the core, active high |
| to_flag | output | 1 | Time-out status, 0 after a watchdog expiry |
| wake_event | output | 1 | Wake-up from sleep by watchdog |

## Verification
`internal_reset` follows a falling `mclr` in the same cycle. It is released at the edge that carries the final counted tick. Watchdog expiry raises it at the edge of the WDT_TICKS-th tick and clears `to_flag` at that same edge. `to_flag` returns to 1 one edge after `wdt_clear`, and `wake_event` drops at the first tick edge after it was set. The bench drives inputs on falling edges, issues each tick as a one-cycle strobe, and reads results at the falling edge after that tick's rising edge. Interval lengths are therefore measured as whole tick counts and compared with the count the requirements give.

// File: rtl/rst_seq_pkg.sv
package rst_seq_pkg;

  typedef enum logic [1:0] {
    OSC_LOWPWR = 2'b00,
    OSC_XTAL   = 2'b01,
    OSC_IRC    = 2'b10,
    OSC_ERC    = 2'b11
  } osc_sel_e;

  // RC modes allow the short hold-off after the first power-on.
  function automatic logic osc_is_rc(osc_sel_e m);
    return (m == OSC_IRC) || (m == OSC_ERC);
  endfunction

endpackage

// File: rtl/rsq_drt_timer.sv
module rsq_drt_timer #(
  parameter int LONG_TICKS  = 576,
  parameter int SHORT_TICKS = 10
) (
  input  logic clk,
  input  logic rst_n,
  input  logic tick,
  input  logic mclr,
  input  logic restart,
  input  logic rc_osc,
  output logic busy
);
  localparam int CW = (LONG_TICKS > 1) ? $clog2(LONG_TICKS) : 1;
  localparam logic [CW-1:0] LONG_LAST  = CW'(LONG_TICKS - 1);
  localparam logic [CW-1:0] SHORT_LAST = CW'(SHORT_TICKS - 1);

  logic [CW-1:0] cnt;
  logic [CW-1:0] last;
  logic          first_pend;   // no hold-off completed since power-on

  always_comb last = (first_pend || !rc_osc) ? LONG_LAST : SHORT_LAST;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy       <= 1'b1;
      cnt        <= '0;
      first_pend <= 1'b1;
    end else if (!mclr || restart) begin
      busy <= 1'b1;
      cnt  <= '0;
    end else if (busy && tick) begin
      if (cnt == last) begin
        busy       <= 1'b0;
        cnt        <= '0;
        first_pend <= 1'b0;
      end else begin
        cnt <= cnt + 1'b1;
      end
    end
  end
endmodule

// File: rtl/rsq_wdt_counter.sv
module rsq_wdt_counter #(
  parameter int PERIOD = 1152
) (
  input  logic clk,
  input  logic rst_n,
  input  logic tick,
  input  logic enable,
  input  logic hold,
  input  logic clear,
  output logic expire
);
  localparam int WW = (PERIOD > 1) ? $clog2(PERIOD) : 1;
  localparam logic [WW-1:0] LAST = WW'(PERIOD - 1);

  logic [WW-1:0] cnt;
  logic          idle;

  always_comb idle = hold || !enable || clear;
  always_comb expire = tick && !idle && (cnt == LAST);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)          cnt <= '0;
    else if (idle)       cnt <= '0;
    else if (tick) begin
      if (cnt == LAST)   cnt <= '0;
      else               cnt <= cnt + 1'b1;
    end
  end
endmodule

// File: rtl/rsq_status.sv
module rsq_status (
  input  logic clk,
  input  logic rst_n,
  input  logic tick,
  input  logic expire,
  input  logic clear,
  input  logic sleep,
  output logic to_flag,
  output logic wake_event
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       to_flag <= 1'b1;
    else if (clear)   to_flag <= 1'b1;
    else if (expire)  to_flag <= 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                 wake_event <= 1'b0;
    else if (expire && sleep)   wake_event <= 1'b1;
    else if (tick)              wake_event <= 1'b0;
  end
endmodule

// File: rtl/rst_seq_wdt.sv
module rst_seq_wdt
  import rst_seq_pkg::*;
#(
  parameter int LONG_TICKS  = 576,
  parameter int SHORT_TICKS = 10,
  parameter int WDT_TICKS   = 1152
) (
  input  logic       clk,
  input  logic       por_n,
  input  logic       mclr,
  input  logic       tick,
  input  logic       sleep,
  input  logic       wdt_clear,
  input  logic [1:0] osc_mode,
  input  logic       wdt_en,
  output logic       internal_reset,
  output logic       to_flag,
  output logic       wake_event
);
  osc_sel_e osc;
  logic     rc_osc;
  logic     hold_busy;
  logic     wdt_expire;

  always_comb osc    = osc_sel_e'(osc_mode);
  always_comb rc_osc = osc_is_rc(osc);
  always_comb internal_reset = hold_busy || !mclr;

  rsq_drt_timer #(
    .LONG_TICKS (LONG_TICKS),
    .SHORT_TICKS(SHORT_TICKS)
  ) u_drt (
    .clk    (clk),
    .rst_n  (por_n),
    .tick   (tick),
    .mclr   (mclr),
    .restart(wdt_expire),
    .rc_osc (rc_osc),
    .busy   (hold_busy)
  );

  rsq_wdt_counter #(
    .PERIOD(WDT_TICKS)
  ) u_wdt (
    .clk   (clk),
    .rst_n (por_n),
    .tick  (tick),
    .enable(wdt_en),
    .hold  (internal_reset),
    .clear (wdt_clear),
    .expire(wdt_expire)
  );

  rsq_status u_stat (
    .clk       (clk),
    .rst_n     (por_n),
    .tick      (tick),
    .expire    (wdt_expire),
    .clear     (wdt_clear),
    .sleep     (sleep),
    .to_flag   (to_flag),
    .wake_event(wake_event)
  );
endmodule

// File: rtl/rst_seq_wdt_chk.sv
module rst_seq_wdt_chk (
  input logic clk,
  input logic por_n,
  input logic mclr,
  input logic tick,
  input logic wdt_clear,
  input logic wdt_en,
  input logic internal_reset,
  input logic to_flag,
  input logic wake_event
);
  AST_MCLR_HOLDS_RESET: assert property (@(posedge clk) disable iff (!por_n)
    !mclr |=> internal_reset); // R2

  AST_RELEASE_ON_TICK: assert property (@(posedge clk) disable iff (!por_n)
    $fell(internal_reset) |-> $past(tick)); // R3

  AST_TO_FALL_IN_RESET: assert property (@(posedge clk) disable iff (!por_n)
    $fell(to_flag) |-> internal_reset); // R7

  AST_WDT_OFF_NO_RESET: assert property (@(posedge clk) disable iff (!por_n)
    (!wdt_en && !internal_reset && mclr) |=> (!mclr || !internal_reset)); // R8

  AST_CLEAR_SETS_TO: assert property (@(posedge clk) disable iff (!por_n)
    wdt_clear |=> to_flag); // R9

  AST_WAKE_WITH_RESET: assert property (@(posedge clk) disable iff (!por_n)
    $rose(wake_event) |-> internal_reset); // R10
endmodule

bind rst_seq_wdt rst_seq_wdt_chk u_chk (
  .clk           (clk),
  .por_n         (por_n),
  .mclr          (mclr),
  .tick          (tick),
  .wdt_clear     (wdt_clear),
  .wdt_en        (wdt_en),
  .internal_reset(internal_reset),
  .to_flag       (to_flag),
  .wake_event    (wake_event)
);

// File: tb/tb_rst_seq_wdt.sv
module tb_rst_seq_wdt;
  localparam int LONG  = 12;
  localparam int SHORT = 3;
  localparam int WDT   = 20;

  logic clk = 1'b0;
  logic por_n, mclr, tick, sleep, wdt_clear, wdt_en;
  logic [1:0] osc_mode;
  logic internal_reset, to_flag, wake_event;
  int n_chk = 0;
  int n_bad = 0;
  bit done = 0;

  always #4 clk = ~clk;

  rst_seq_wdt #(.LONG_TICKS(LONG), .SHORT_TICKS(SHORT), .WDT_TICKS(WDT)) dut (
    .clk(clk), .por_n(por_n), .mclr(mclr), .tick(tick), .sleep(sleep),
    .wdt_clear(wdt_clear), .osc_mode(osc_mode), .wdt_en(wdt_en),
    .internal_reset(internal_reset), .to_flag(to_flag), .wake_event(wake_event));

  function automatic int exp_len(logic [1:0] m, bit first);
    return (first || !m[1]) ? LONG : SHORT;
  endfunction

  task automatic check(string req, int act, int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic do_tick();
    tick = 1'b1;
    @(negedge clk);
    tick = 1'b0;
    @(negedge clk);
  endtask

  task automatic pulse_clear();
    wdt_clear = 1'b1;
    @(negedge clk);
    wdt_clear = 1'b0;
    @(negedge clk);
  endtask

  task automatic ticks_in_reset(output int n);
    n = 0;
    while (internal_reset && n < 500) begin do_tick(); n++; end
  endtask

  task automatic ticks_to_reset(output int n);
    n = 0;
    while (!internal_reset && n < 500) begin do_tick(); n++; end
  endtask

  task automatic mclr_pulse(int low_ticks);
    mclr = 1'b0;
    #1;
    check("R2 reset at once on mclr low", internal_reset, 1);
    @(negedge clk);
    for (int i = 0; i < low_ticks; i++) do_tick();
    check("R2 reset held while mclr low", internal_reset, 1);
    mclr = 1'b1;
    @(negedge clk);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    int n;
    void'($urandom(32'd1234));
    por_n = 0; mclr = 0; tick = 0; sleep = 0; wdt_clear = 0;
    osc_mode = 2'b10; wdt_en = 1;
    repeat (3) @(negedge clk);
    check("R1 reset out", internal_reset, 1);
    check("R1 to_flag", to_flag, 1);
    check("R1 wake_event", wake_event, 0);

    por_n = 1;
    @(negedge clk);
    for (int i = 0; i < 5; i++) do_tick();
    check("R2 no count while mclr low", internal_reset, 1);
    mclr = 1;
    @(negedge clk);
    ticks_in_reset(n);
    check("R3 power-on hold in RC mode", n, LONG);

    ticks_to_reset(n);
    check("R6 watchdog period", n, WDT);
    check("R7 to_flag after expiry", to_flag, 0);
    check("R10 no wake when awake", wake_event, 0);
    ticks_in_reset(n);
    check("R6 R4 hold after expiry", n, SHORT);
    pulse_clear();
    check("R9 clear sets to_flag", to_flag, 1);

    mclr_pulse(2);
    ticks_in_reset(n);
    check("R4 later hold internal RC", n, SHORT);
    osc_mode = 2'b01;
    mclr_pulse(1);
    ticks_in_reset(n);
    check("R5 later hold crystal", n, LONG);
    osc_mode = 2'b00;
    mclr_pulse(0);
    ticks_in_reset(n);
    check("R5 later hold low power", n, LONG);

    wdt_en = 0;
    for (int i = 0; i < 3 * WDT; i++) do_tick();
    check("R8 disabled watchdog no reset", internal_reset, 0);
    wdt_en = 1;

    for (int k = 0; k < 4; k++) begin
      for (int i = 0; i < WDT - 1; i++) do_tick();
      pulse_clear();
    end
    check("R9 clears prevent reset", internal_reset, 0);
    check("R9 to_flag after clears", to_flag, 1);

    osc_mode = 2'b11;
    sleep = 1;
    ticks_to_reset(n);
    check("R10 expiry in sleep period", n, WDT);
    check("R10 wake raised", wake_event, 1);
    do_tick();
    check("R10 wake cleared next tick", wake_event, 0);
    sleep = 0;
    ticks_in_reset(n);
    check("R4 hold after sleep expiry", n, SHORT - 1);

    for (int it = 0; it < 24; it++) begin
      int kind;
      logic [1:0] m;
      m = 2'($urandom % 4);
      kind = int'($urandom % 3);
      osc_mode = m;
      if (kind == 0) begin
        por_n = 0;
        @(negedge clk);
        check("R1 to_flag during por", to_flag, 1);
        por_n = 1;
        @(negedge clk);
        ticks_in_reset(n);
        check("R3 power-on hold random mode", n, exp_len(m, 1'b1));
      end else if (kind == 1) begin
        mclr_pulse(int'($urandom % 4));
        ticks_in_reset(n);
        check(m[1] ? "R4 later hold random" : "R5 later hold random", n, exp_len(m, 1'b0));
      end else begin
        int reps;
        reps = 1 + int'($urandom % 3);
        for (int k = 0; k < reps; k++) begin
          int gap;
          gap = 1 + int'($urandom % (WDT - 1));
          for (int i = 0; i < gap; i++) do_tick();
          pulse_clear();
        end
        check("R9 random clears keep core running", internal_reset, 0);
      end
    end

    done = 1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule